// File: doc/BRIEF.md
# Ring Token Output Reservation

This block settles, once per slot, which port controller of a switch may send its head-of-line cell to which outlet. The N controllers sit on a one-way ring. When a slot starts, the frame source at ring position 0 sends out a serial frame of N one-bit fields, all clear. Field j stands for outlet j, with 0 meaning free and 1 meaning taken. The bits pass from controller to controller. A controller that wants outlet j and finds field j clear sets the field and wins the outlet. If the field is already set, the controller loses and must ask again in a later slot. Because every controller examines a field before the controllers after it on the ring, positions nearer the frame source have implicit priority.

A fill mode, chosen per slot, sends the frame around the ring a second time. On that lap every controller that holds no outlet sets the first clear field it sees and takes that outlet, so each controller ends up paired with exactly one outlet. The results are latched when the last bit of the final lap reaches the frame source, and a one-cycle done pulse is raised at the same edge. The results then stay unchanged through the whole of the next slot's reservation, so that the winners of one slot can send their cells while the next slot's frame is circulating.

Top module: `ring_outlet_reserve`

## Requirements
- R1: While reset is active and after it is released, `slot_done`, `grant`, `assign_valid` and `assign_outlet` are all zero until the first slot completes.
- R2: On the first lap, a requesting port is granted outlet j exactly when no port with a lower ring index requested j in the same slot. At most one grant is given per outlet.
- R3: A port with `req_valid` low never receives a grant. In single-lap mode, a port that is not granted reports `assign_valid` 0 and an outlet value of 0.
- R4: `slot_done` rises 2N clock edges after the accepting `slot_start` edge in single-lap mode, or 3N edges after it in fill mode, and stays high for exactly one cycle.
- R5: In fill mode, ports without a grant are visited in ascending index order. Each one takes the lowest-numbered outlet still free at that point. `assign_valid` is then all ones, and the outlets form a permutation of 0..N-1.
- R6: A granted port reports `assign_valid` 1, and its outlet field equals the outlet it requested.
- R7: `grant`, `assign_valid` and `assign_outlet` change only at the edge where `slot_done` rises. They hold their values while the next slot's reservation runs.
- R8: A `slot_start` pulse that arrives while a reservation is running is ignored. It neither restarts the current slot nor starts another one.
- R9: `req_valid`, `req_outlet` and `fill_mode` are sampled only at the accepting `slot_start` edge. Changing them later has no effect on that slot's result.
- R10: Port p's requested outlet is `req_outlet[p*W +: W]`, and its result is `assign_outlet[p*W +: W]`, where W = log2(N).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_start | input | 1 | Starts a reservation slot when the block is idle |
| fill_mode | input | 1 | 1 selects the second lap that pairs idle ports with free outlets |
| req_valid | input | N | Port p holds a head-of-line cell |
| req_outlet | input | N*W | Requested outlet per port, field p at [p*W +: W] |
| slot_done | output | 1 | One-cycle pulse when the results are latched |
| grant | output | N | Port p won its requested outlet on the first lap |
| assign_valid | output | N | Port p holds an outlet for the coming slot |
| assign_outlet | output | N*W | Outlet held by each port, 0 if none |

## Verification
A frame field that is lost, flipped or read out of step on the ring shows up in the latched grant pattern when `slot_done` rises. A cleared reserved bit gives two ports the same outlet. A misaligned field index makes a port win an outlet it never asked for. A shifted position counter inside a node shows in the fill-mode permutation, or in the done pulse arriving away from 2N or 3N edges. All of these appear at the end of the very slot in which the fault occurs, because the node state is cleared at every accepted start. Outputs that move between done pulses would break the pipelined use of the results, so they are compared against the previous slot's values on every cycle.

// File: rtl/rr_pkg.sv
// Shared types for the ring outlet reservation block.
// Assumes nothing beyond a single clock domain.
package rr_pkg;
    // Phases of the frame source at ring position 0
    typedef enum logic [1:0] {
        ORG_IDLE   = 2'd0,
        ORG_INJECT = 2'd1,
        ORG_LAP1   = 2'd2,
        ORG_LAP2   = 2'd3
    } org_state_e;
endpackage

// File: rtl/rr_frame_origin.sv
// Frame source at ring position 0: emits N clear field bits after an
// accepted start, then watches the stream come back. In fill mode it
// feeds the first returning lap into the ring again for a second lap.
// It flags the edge at which the last bit of the final lap returns.
// Assumes N >= 2 and that the ring adds one register per node.
module rr_frame_origin #(
    parameter int N  = 8,
    localparam int CW = (N > 1) ? $clog2(N) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic fill_i,
    input  logic ret_vld_i,
    input  logic ret_fld_i,
    output logic inj_vld_o,
    output logic inj_fld_o,
    output logic load_o,
    output logic finish_o,
    output logic fill_q_o
);
    import rr_pkg::*;

    org_state_e    state;
    logic [CW-1:0] cnt;
    logic          last_bit;

    assign last_bit = (cnt == CW'(N - 1));
    assign load_o   = start_i && (state == ORG_IDLE);
    assign finish_o = ret_vld_i && last_bit &&
                      ((state == ORG_LAP1 && !fill_q_o) || state == ORG_LAP2);

    // Select what enters node 0: fresh clear fields, the returned lap, or nothing
    always_comb begin
        inj_vld_o = 1'b0;
        inj_fld_o = 1'b0;
        case (state)
            ORG_INJECT: begin
                inj_vld_o = 1'b1;
                inj_fld_o = 1'b0;
            end
            ORG_LAP1: begin
                inj_vld_o = fill_q_o && ret_vld_i;
                inj_fld_o = ret_fld_i;
            end
            default: begin
                inj_vld_o = 1'b0;
                inj_fld_o = 1'b0;
            end
        endcase
    end

    // Phase sequencing and bit counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ORG_IDLE;
            cnt      <= '0;
            fill_q_o <= 1'b0;
        end else begin
            case (state)
                ORG_IDLE: begin
                    if (start_i) begin
                        state    <= ORG_INJECT;
                        cnt      <= '0;
                        fill_q_o <= fill_i;
                    end
                end
                ORG_INJECT: begin
                    if (last_bit) begin
                        state <= ORG_LAP1;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ORG_LAP1: begin
                    if (ret_vld_i) begin
                        if (last_bit) begin
                            cnt   <= '0;
                            state <= fill_q_o ? ORG_LAP2 : ORG_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    if (ret_vld_i) begin
                        if (last_bit) begin
                            cnt   <= '0;
                            state <= ORG_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // R4
    // Returning bits are only seen while a lap is expected
    ret_in_lap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_vld_i |-> (state == ORG_LAP1 || state == ORG_LAP2));

    // R8
    // A start while busy leaves the phase untouched
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && state == ORG_INJECT && !last_bit) |=> (state == ORG_INJECT));
endmodule

// File: rtl/rr_port_node.sv
// One port controller on the ring. It latches its request at an accepted
// start. Each frame bit is passed on through one register. On the first
// lap the node sets the field of its requested outlet if that field is
// clear. On the second lap, if it holds nothing yet, it sets the first
// clear field it sees. It assumes the frame bits arrive in index order
// with no gaps inside a lap.
module rr_port_node #(
    parameter int N = 8,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         req_i,
    input  logic [W-1:0] dest_i,
    input  logic         in_vld_i,
    input  logic         in_fld_i,
    output logic         out_vld_o,
    output logic         out_fld_o,
    output logic         holds_o,
    output logic         won_o,
    output logic [W-1:0] outlet_o
);
    logic         want;
    logic [W-1:0] dest_q;
    logic [W-1:0] idx;
    logic         lap;
    logic         filled;
    logic [W-1:0] fill_idx;
    logic         take_r1;
    logic         take_r2;

    // Decide whether this node claims the field passing now
    always_comb begin
        take_r1 = in_vld_i && !lap && want && (idx == dest_q) && !in_fld_i;
        take_r2 = in_vld_i && lap && !won_o && !filled && !in_fld_i;
    end

    assign holds_o  = won_o || filled;
    assign outlet_o = won_o ? dest_q : fill_idx;

    // Request capture, field tracking and the one-stage frame register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            want      <= 1'b0;
            dest_q    <= '0;
            idx       <= '0;
            lap       <= 1'b0;
            won_o     <= 1'b0;
            filled    <= 1'b0;
            fill_idx  <= '0;
            out_vld_o <= 1'b0;
            out_fld_o <= 1'b0;
        end else if (load_i) begin
            want      <= req_i;
            dest_q    <= dest_i;
            idx       <= '0;
            lap       <= 1'b0;
            won_o     <= 1'b0;
            filled    <= 1'b0;
            fill_idx  <= '0;
            out_vld_o <= 1'b0;
            out_fld_o <= 1'b0;
        end else begin
            out_vld_o <= in_vld_i;
            out_fld_o <= in_fld_i || take_r1 || take_r2;
            if (in_vld_i) begin
                if (idx == W'(N - 1)) begin
                    idx <= '0;
                    lap <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
            if (take_r1) begin
                won_o <= 1'b1;
            end
            if (take_r2) begin
                filled   <= 1'b1;
                fill_idx <= idx;
            end
        end
    end

    // R2
    // A field that arrives reserved leaves reserved one cycle later
    fld_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld_i && in_fld_i && !load_i) |=> (out_vld_o && out_fld_o));

    // R3
    // Only a node that latched a request can win on the first lap
    win_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        won_o |-> want);

    // R5
    // A node never holds both a won and a filled outlet
    single_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(won_o && filled));
endmodule

// File: rtl/ring_outlet_reserve.sv
// Top of the ring reservation block. It chains N port nodes into a ring
// with the frame source at position 0. When the final lap returns it
// latches the per-port results and pulses slot_done. The results stay
// stable until the next pulse, so one slot's winners can transmit while
// the next slot reserves. Assumes N is a power of two, N >= 2.
module ring_outlet_reserve #(
    parameter int N = 8,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           slot_start,
    input  logic           fill_mode,
    input  logic [N-1:0]   req_valid,
    input  logic [N*W-1:0] req_outlet,
    output logic           slot_done,
    output logic [N-1:0]   grant,
    output logic [N-1:0]   assign_valid,
    output logic [N*W-1:0] assign_outlet
);
    logic           inj_vld;
    logic           inj_fld;
    logic           load;
    logic           finish;
    logic           fill_q;
    logic [N-1:0]   ring_vld;
    logic [N-1:0]   ring_fld;
    logic [N-1:0]   node_won;
    logic [N-1:0]   node_holds;
    logic [N*W-1:0] node_outlet;

    rr_frame_origin #(.N(N)) u_origin (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (slot_start),
        .fill_i    (fill_mode),
        .ret_vld_i (ring_vld[N-1]),
        .ret_fld_i (ring_fld[N-1]),
        .inj_vld_o (inj_vld),
        .inj_fld_o (inj_fld),
        .load_o    (load),
        .finish_o  (finish),
        .fill_q_o  (fill_q)
    );

    for (genvar p = 0; p < N; p++) begin : g_node
        logic in_vld;
        logic in_fld;
        if (p == 0) begin : g_head
            assign in_vld = inj_vld;
            assign in_fld = inj_fld;
        end else begin : g_chain
            assign in_vld = ring_vld[p-1];
            assign in_fld = ring_fld[p-1];
        end
        rr_port_node #(.N(N)) u_node (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_i    (load),
            .req_i     (req_valid[p]),
            .dest_i    (req_outlet[p*W +: W]),
            .in_vld_i  (in_vld),
            .in_fld_i  (in_fld),
            .out_vld_o (ring_vld[p]),
            .out_fld_o (ring_fld[p]),
            .holds_o   (node_holds[p]),
            .won_o     (node_won[p]),
            .outlet_o  (node_outlet[p*W +: W])
        );
    end

    // Latch the slot results when the final lap has returned
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_done     <= 1'b0;
            grant         <= '0;
            assign_valid  <= '0;
            assign_outlet <= '0;
        end else begin
            slot_done <= finish;
            if (finish) begin
                grant         <= node_won;
                assign_valid  <= node_holds;
                assign_outlet <= node_outlet;
            end
        end
    end

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_done |=> !slot_done);

    // R7
    hold_results_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_done |-> ($stable(grant) && $stable(assign_valid) && $stable(assign_outlet)));

    // R5
    fill_covers_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_done && fill_q) |-> (&assign_valid));

    // R6
    grant_has_outlet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_done |-> ((grant & ~assign_valid) == '0));
endmodule

// File: tb/ring_outlet_reserve_tb.sv
module ring_outlet_reserve_tb;
    localparam int N = 8;
    localparam int W = $clog2(N);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           slot_start = 1'b0;
    logic           fill_mode = 1'b0;
    logic [N-1:0]   req_valid = '0;
    logic [N*W-1:0] req_outlet = '0;
    logic           slot_done;
    logic [N-1:0]   grant;
    logic [N-1:0]   assign_valid;
    logic [N*W-1:0] assign_outlet;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [N-1:0]   prev_g = '0;
    logic [N-1:0]   prev_av = '0;
    logic [N*W-1:0] prev_o = '0;

    always #10 clk = ~clk;

    ring_outlet_reserve #(.N(N)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .slot_start    (slot_start),
        .fill_mode     (fill_mode),
        .req_valid     (req_valid),
        .req_outlet    (req_outlet),
        .slot_done     (slot_done),
        .grant         (grant),
        .assign_valid  (assign_valid),
        .assign_outlet (assign_outlet)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference: first lap in ring order, then optional fill lap
    task automatic model(input logic [N-1:0] rq, input logic [N*W-1:0] ds, input logic fm,
                         output logic [N-1:0] g, output logic [N-1:0] av,
                         output logic [N*W-1:0] oo);
        logic [N-1:0] res;
        res = '0; g = '0; av = '0; oo = '0;
        for (int p = 0; p < N; p++) begin
            logic [W-1:0] d;
            d = ds[p*W +: W];
            if (rq[p] && !res[d]) begin
                res[d] = 1'b1; g[p] = 1'b1; av[p] = 1'b1; oo[p*W +: W] = d;
            end
        end
        if (fm) begin
            for (int p = 0; p < N; p++) begin
                bit found;
                found = 0;
                if (!g[p]) begin
                    for (int j = 0; j < N; j++) begin
                        if (!found && !res[j]) begin
                            found = 1; res[j] = 1'b1; av[p] = 1'b1; oo[p*W +: W] = W'(j);
                        end
                    end
                end
            end
        end
    endtask

    task automatic run_slot(input logic [N-1:0] rq, input logic [N*W-1:0] ds,
                            input logic fm, input bit disturb);
        logic [N-1:0]   eg;
        logic [N-1:0]   eav;
        logic [N*W-1:0] eo;
        int  m;
        bit  seen;
        bit  stable_ok;
        bit  extra;
        model(rq, ds, fm, eg, eav, eo);
        @(negedge clk);
        req_valid = rq; req_outlet = ds; fill_mode = fm; slot_start = 1'b1;
        @(negedge clk);
        slot_start = 1'b0;
        if (disturb) begin
            req_valid = ~rq;
            req_outlet = ~ds;
            fill_mode = ~fm;
        end
        m = 0; seen = 0; stable_ok = 1;
        while (!seen && m < 4*N + 8) begin
            @(negedge clk);
            m++;
            slot_start = (disturb && m == 2) ? 1'b1 : 1'b0;
            if (slot_done) seen = 1;
            else if (grant !== prev_g || assign_valid !== prev_av || assign_outlet !== prev_o)
                stable_ok = 0;
        end
        slot_start = 1'b0;
        chk(stable_ok, "R7 outputs held during reservation", 64'(stable_ok), 64'd1);
        chk(seen && m == (fm ? 3*N : 2*N), disturb ? "R4/R8 done latency" : "R4 done latency",
            64'(m), 64'(fm ? 3*N : 2*N));
        chk(grant === eg, disturb ? "R9 grant after input change" : "R2 grant pattern",
            64'(grant), 64'(eg));
        chk(assign_valid === eav, fm ? "R5 assign_valid" : "R3 assign_valid",
            64'(assign_valid), 64'(eav));
        chk(assign_outlet === eo, fm ? "R5 outlet map" : "R6 R10 outlet map",
            64'(assign_outlet), 64'(eo));
        @(negedge clk);
        chk(slot_done === 1'b0, "R4 single-cycle done", 64'(slot_done), 64'd0);
        if (disturb) begin
            extra = 0;
            for (int k = 0; k < 4*N; k++) begin
                @(negedge clk);
                if (slot_done) extra = 1;
            end
            chk(!extra, "R8 start while busy ignored", 64'(extra), 64'd0);
        end
        prev_g = eg; prev_av = eav; prev_o = eo;
    endtask

    function automatic logic [N*W-1:0] rand_dests();
        logic [N*W-1:0] v;
        for (int p = 0; p < N; p++) v[p*W +: W] = W'($urandom_range(N-1));
        return v;
    endfunction

    function automatic logic [N*W-1:0] same_dest(input int d);
        logic [N*W-1:0] v;
        for (int p = 0; p < N; p++) v[p*W +: W] = W'(d);
        return v;
    endfunction

    function automatic logic [N*W-1:0] rev_dests();
        logic [N*W-1:0] v;
        for (int p = 0; p < N; p++) v[p*W +: W] = W'(N - 1 - p);
        return v;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        chk(slot_done === 1'b0 && grant === '0 && assign_valid === '0 && assign_outlet === '0,
            "R1 outputs during reset", 64'(grant), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(slot_done === 1'b0 && grant === '0 && assign_valid === '0 && assign_outlet === '0,
            "R1 outputs after reset", 64'(assign_valid), 64'd0);

        // Directed corners
        run_slot('1, same_dest(0), 1'b0, 0);     // R2 only port 0 wins
        run_slot('1, same_dest(3), 1'b1, 0);     // R5 fill around outlet 3
        run_slot('1, rev_dests(), 1'b0, 0);      // R6 all distinct, all granted
        run_slot('0, same_dest(5), 1'b0, 0);     // R3 no requests, no grants
        run_slot('0, same_dest(5), 1'b1, 0);     // R5 identity fill
        run_slot(8'b1010_0101, same_dest(2), 1'b1, 1);  // R8 R9

        for (int s = 0; s < 150; s++) begin
            logic [N-1:0] rq;
            rq = N'($urandom);
            run_slot(rq, rand_dests(), 1'($urandom_range(1)), ($urandom_range(9) == 0));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule